// File: doc/BRIEF.md
# Boot Message Stream Interpreter

This block sits between a serial fetch engine that streams bytes out of a boot memory and a register bus that loads configuration into a processing core. It takes the bytes one at a time over a valid/ready input and reads them as a sequence of typed messages. Each message starts with a one-byte identifier. Write messages carry a length and a payload. The payload is a chip address, a 16-bit subaddress and the data bytes, and it leaves the block as a byte stream with start and last markers.

The other messages add no traffic on the write port. They do one of these: pause the input for a programmable time, pad the stream so that later messages fall at fixed memory positions, set persistent writeback configuration flags, or end the stream. The stream can end plainly, or it can end with the block armed to wait for a writeback trigger. A malformed stream halts parsing and raises an error flag. Only reset clears it.

Top module: `boot_msg_interp`

## Requirements
- R1: After reset, in_ready is 1, wr_valid is 0, and done, error, multi_wb, wb_falling and wb_armed are all 0. The first byte accepted is read as a message identifier.
- R2: Identifier 0x00 sets done. From the next cycle in_ready stays 0 and no further byte is taken. wb_armed stays 0.
- R3: Identifier 0x01 is followed by two length bytes, high byte first. Exactly that many payload bytes follow, and the length counts the chip address and both subaddress bytes. Each payload byte appears on wr_byte with wr_valid high in the cycle after it was accepted, in stream order.
- R4: wr_start is high only with the first payload byte (the chip address), and wr_last only with the final payload byte. The byte accepted after the final payload byte is read as a new identifier.
- R5: A write length below 3 sets error and stops parsing (in_ready 0). No write-port activity results.
- R6: Identifier 0x02 is followed by a two-byte big-endian delay D. After the second delay byte is accepted, in_ready is 0 for exactly D*DELAY_UNIT cycles. With D = 0 there is no stall.
- R7: Identifier 0x03 is accepted and changes nothing: no write, no flag. Any number of them may appear in a row.
- R8: Identifier 0x04 sets multi_wb and 0x05 sets wb_falling. Each stays set until reset.
- R9: Identifier 0x06 sets both done and wb_armed and stops intake.
- R10: Any identifier above 0x06 sets error, leaves done at 0 and stops intake.
- R11: done and error hold until reset, and reset returns the block to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_byte | input | 8 | Incoming stream byte |
| in_valid | input | 1 | in_byte is valid |
| in_ready | output | 1 | Block accepts a byte this cycle |
| wr_byte | output | 8 | Write payload byte |
| wr_valid | output | 1 | wr_byte is valid this cycle |
| wr_start | output | 1 | First payload byte of a write (chip address) |
| wr_last | output | 1 | Final payload byte of a write |
| done | output | 1 | Stream ended normally |
| error | output | 1 | Malformed stream, parsing halted |
| multi_wb | output | 1 | Multiple-writeback flag |
| wb_falling | output | 1 | Writeback trigger is falling-edge sensitive |
| wb_armed | output | 1 | Ended and waiting for a writeback trigger |

## Verification
The situation hardest to reach is a write whose final byte arrives right after other messages have changed state: padding, flag setting and a second write must all follow each other, and the start and last markers must land on the correct bytes. One stream table mixes every message kind in front of two writes of different lengths. The bench checks the collected write log against an expected table. The stall length is measured at the ports in clock cycles for both a nonzero and a zero delay. The error paths each get a stream of their own, with reset applied in between.

// File: rtl/bmi_pkg.sv
package bmi_pkg;
   typedef enum logic [2:0] {
      ST_ID,
      ST_LEN_HI,
      ST_LEN_LO,
      ST_PAY,
      ST_DLY_HI,
      ST_DLY_LO,
      ST_WAIT,
      ST_STOP
   } bmi_state_t;

   localparam logic [7:0] MSG_END      = 8'h00;
   localparam logic [7:0] MSG_WRITE    = 8'h01;
   localparam logic [7:0] MSG_DELAY    = 8'h02;
   localparam logic [7:0] MSG_NOP      = 8'h03;
   localparam logic [7:0] MSG_MULTI    = 8'h04;
   localparam logic [7:0] MSG_FALLING  = 8'h05;
   localparam logic [7:0] MSG_END_WAIT = 8'h06;
endpackage

// File: rtl/bmi_down_counter.sv
module bmi_down_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic         is_one
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (dec && cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign is_one = (cnt_q == W'(1));
endmodule

// File: rtl/bmi_pair_reg.sv
module bmi_pair_reg #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take_hi,
   input  logic [BYTE_W-1:0] byte_in,
   output logic [2*BYTE_W-1:0] pair
);
   logic [BYTE_W-1:0] hi_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         hi_q <= '0;
      else if (take_hi)
         hi_q <= byte_in;
   end

   assign pair = {hi_q, byte_in};
endmodule

// File: rtl/bmi_flag_bank.sv
module bmi_flag_bank #(
   parameter int N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   output logic [N-1:0] flags
);
   for (genvar i = 0; i < N; i++) begin : g_flag
      logic f_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            f_q <= 1'b0;
         else if (set[i])
            f_q <= 1'b1;
      end
      assign flags[i] = f_q;
   end
endmodule

// File: rtl/boot_msg_interp.sv
module boot_msg_interp
   import bmi_pkg::*;
#(
   parameter int BYTE_W     = 8,
   parameter int DELAY_UNIT = 4,
   parameter int MIN_LEN    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTE_W-1:0] in_byte,
   input  logic              in_valid,
   output logic              in_ready,
   output logic [BYTE_W-1:0] wr_byte,
   output logic              wr_valid,
   output logic              wr_start,
   output logic              wr_last,
   output logic              done,
   output logic              error,
   output logic              multi_wb,
   output logic              wb_falling,
   output logic              wb_armed
);
   localparam int LEN_W = 2 * BYTE_W;
   localparam int DLY_W = LEN_W + $clog2(DELAY_UNIT) + 1;
   localparam int F_DONE = 0, F_ERR = 1, F_MULTI = 2, F_FALL = 3, F_ARM = 4;
   localparam int NFLAG = 5;

   if (BYTE_W != 8) begin : g_chk_byte
      $error("BYTE_W must be 8");
   end
   if (DELAY_UNIT < 1) begin : g_chk_unit
      $error("DELAY_UNIT must be at least 1");
   end
   if (MIN_LEN < 1) begin : g_chk_len
      $error("MIN_LEN must be at least 1");
   end

   bmi_state_t state_q, state_d;
   logic accept;
   logic [LEN_W-1:0] pair;
   logic [DLY_W-1:0] dly_total;
   logic len_load, len_dec, len_one;
   logic dly_load, dly_dec, dly_one;
   logic first_q;
   logic [NFLAG-1:0] flag_set, flags;
   logic wr_valid_q, wr_start_q, wr_last_q;
   logic [BYTE_W-1:0] wr_byte_q;

   assign in_ready = (state_q != ST_WAIT) && (state_q != ST_STOP);
   assign accept   = in_valid && in_ready;

   bmi_pair_reg #(.BYTE_W(BYTE_W)) u_pair (
      .clk     (clk),
      .rst_n   (rst_n),
      .take_hi (accept && (state_q == ST_LEN_HI || state_q == ST_DLY_HI)),
      .byte_in (in_byte),
      .pair    (pair)
   );

   if (DELAY_UNIT == 1) begin : g_unit_one
      assign dly_total = DLY_W'(pair);
   end else begin : g_unit_mul
      assign dly_total = DLY_W'(pair) * DLY_W'(DELAY_UNIT);
   end

   assign len_load = accept && (state_q == ST_LEN_LO) && (pair >= LEN_W'(MIN_LEN));
   assign len_dec  = accept && (state_q == ST_PAY);

   bmi_down_counter #(.W(LEN_W)) u_len_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (len_load),
      .load_val (pair),
      .dec      (len_dec),
      .is_one   (len_one)
   );

   assign dly_load = accept && (state_q == ST_DLY_LO) && (dly_total != '0);
   assign dly_dec  = (state_q == ST_WAIT);

   bmi_down_counter #(.W(DLY_W)) u_dly_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (dly_load),
      .load_val (dly_total),
      .dec      (dly_dec),
      .is_one   (dly_one)
   );

   always_comb begin
      state_d  = state_q;
      flag_set = '0;
      case (state_q)
         ST_ID: if (accept) begin
            case (in_byte)
               MSG_END:      begin state_d = ST_STOP; flag_set[F_DONE] = 1'b1; end
               MSG_WRITE:    state_d = ST_LEN_HI;
               MSG_DELAY:    state_d = ST_DLY_HI;
               MSG_NOP:      state_d = ST_ID;
               MSG_MULTI:    flag_set[F_MULTI] = 1'b1;
               MSG_FALLING:  flag_set[F_FALL] = 1'b1;
               MSG_END_WAIT: begin
                  state_d = ST_STOP;
                  flag_set[F_DONE] = 1'b1;
                  flag_set[F_ARM]  = 1'b1;
               end
               default:      begin state_d = ST_STOP; flag_set[F_ERR] = 1'b1; end
            endcase
         end
         ST_LEN_HI: if (accept) state_d = ST_LEN_LO;
         ST_LEN_LO: if (accept) begin
            if (len_load) state_d = ST_PAY;
            else begin state_d = ST_STOP; flag_set[F_ERR] = 1'b1; end
         end
         ST_PAY:    if (accept && len_one) state_d = ST_ID;
         ST_DLY_HI: if (accept) state_d = ST_DLY_LO;
         ST_DLY_LO: if (accept) state_d = dly_load ? ST_WAIT : ST_ID;
         ST_WAIT:   if (dly_one) state_d = ST_ID;
         default:   state_d = ST_STOP;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_ID;
         first_q    <= 1'b0;
         wr_valid_q <= 1'b0;
         wr_start_q <= 1'b0;
         wr_last_q  <= 1'b0;
         wr_byte_q  <= '0;
      end else begin
         state_q    <= state_d;
         wr_valid_q <= len_dec;
         wr_start_q <= len_dec && first_q;
         wr_last_q  <= len_dec && len_one;
         if (len_dec) wr_byte_q <= in_byte;
         if (len_load) first_q <= 1'b1;
         else if (len_dec) first_q <= 1'b0;
      end
   end

   bmi_flag_bank #(.N(NFLAG)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (flag_set),
      .flags (flags)
   );

   assign wr_byte    = wr_byte_q;
   assign wr_valid   = wr_valid_q;
   assign wr_start   = wr_start_q;
   assign wr_last    = wr_last_q;
   assign done       = flags[F_DONE];
   assign error      = flags[F_ERR];
   assign multi_wb   = flags[F_MULTI];
   assign wb_falling = flags[F_FALL];
   assign wb_armed   = flags[F_ARM];
endmodule

// File: rtl/boot_msg_interp_chk.sv
module boot_msg_interp_chk (
   input logic clk,
   input logic rst_n,
   input logic in_ready,
   input logic wr_valid,
   input logic wr_start,
   input logic wr_last,
   input logic done,
   input logic error,
   input logic multi_wb,
   input logic wb_falling,
   input logic wb_armed
);
   assert_done_blocks_input_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !in_ready);
   assert_error_blocks_input_R10: assert property (@(posedge clk) disable iff (!rst_n)
      error |-> !in_ready);
   assert_done_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done);
   assert_error_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      error |=> error);
   assert_armed_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wb_armed |-> done);
   assert_marks_need_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_start || wr_last) |-> wr_valid);
   assert_multi_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      multi_wb |=> multi_wb);
   assert_falling_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wb_falling |=> wb_falling);
   assert_no_write_after_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (done || error) |=> !wr_valid);
endmodule

bind boot_msg_interp boot_msg_interp_chk i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_ready   (in_ready),
   .wr_valid   (wr_valid),
   .wr_start   (wr_start),
   .wr_last    (wr_last),
   .done       (done),
   .error      (error),
   .multi_wb   (multi_wb),
   .wb_falling (wb_falling),
   .wb_armed   (wb_armed)
);

// File: tb/test_boot_msg_interp.sv
module test_boot_msg_interp;
   localparam int UNIT = 4;
   localparam int NSTIM = 19;
   localparam int NEXP = 8;
   // mixed stream: nop, multi, write(len5), nop, write(len3), falling, end
   localparam logic [7:0] STIM [NSTIM] = '{
      8'h03, 8'h04, 8'h01, 8'h00, 8'h05, 8'h00, 8'h08, 8'h00, 8'hAB, 8'hCD,
      8'h03, 8'h01, 8'h00, 8'h03, 8'h00, 8'h1C, 8'h00, 8'h05, 8'h00};
   // {start, last, byte}
   localparam logic [9:0] EXP [NEXP] = '{
      {2'b10, 8'h00}, {2'b00, 8'h08}, {2'b00, 8'h00}, {2'b00, 8'hAB},
      {2'b01, 8'hCD}, {2'b10, 8'h00}, {2'b00, 8'h1C}, {2'b01, 8'h00}};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [7:0] in_byte = '0;
   logic in_valid = 1'b0;
   logic in_ready, wr_valid, wr_start, wr_last;
   logic [7:0] wr_byte;
   logic done, error, multi_wb, wb_falling, wb_armed;

   int checks = 0;
   int fails = 0;
   int nlog = 0;
   logic [9:0] wlog [32];

   always #2.5 clk = ~clk;

   boot_msg_interp #(.DELAY_UNIT(UNIT)) i_boot_msg_interp (
      .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_valid(in_valid),
      .in_ready(in_ready), .wr_byte(wr_byte), .wr_valid(wr_valid),
      .wr_start(wr_start), .wr_last(wr_last), .done(done), .error(error),
      .multi_wb(multi_wb), .wb_falling(wb_falling), .wb_armed(wb_armed));

   always @(negedge clk) begin
      if (wr_valid && nlog < 32) begin
         wlog[nlog] = {wr_start, wr_last, wr_byte};
         nlog = nlog + 1;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      in_valid = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      nlog = 0;
   endtask

   task automatic send(input logic [7:0] b);
      @(negedge clk);
      in_valid = 1'b1;
      in_byte = b;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      #1;
      in_valid = 1'b0;
   endtask

   task automatic stall_len(output int n);
      n = 0;
      @(negedge clk);
      while (!in_ready && n < 1000) begin
         n++;
         @(negedge clk);
      end
   endtask

   initial begin
      #400000;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int n;
      do_reset();
      @(negedge clk);
      check("R1 in_ready", 32'(in_ready), 1);
      check("R1 flags", {27'b0, done, error, multi_wb, wb_falling, wb_armed}, 0);
      check("R1 wr_valid", 32'(wr_valid), 0);

      for (int i = 0; i < NSTIM; i++) send(STIM[i]);
      @(negedge clk);
      check("R3 R7 write count", nlog, NEXP);
      for (int i = 0; i < NEXP; i++) check("R3 R4 write entry", 32'(wlog[i]), 32'(EXP[i]));
      check("R2 done", 32'(done), 1);
      check("R2 armed clear", 32'(wb_armed), 0);
      check("R8 multi_wb", 32'(multi_wb), 1);
      check("R8 wb_falling", 32'(wb_falling), 1);
      check("R2 in_ready", 32'(in_ready), 0);
      in_valid = 1'b1;
      in_byte = 8'h01;
      repeat (5) @(negedge clk);
      in_valid = 1'b0;
      check("R11 done holds", 32'(done), 1);
      check("R2 no traffic after end", nlog, NEXP);

      do_reset();
      @(negedge clk);
      check("R11 reset clears", {27'b0, done, error, multi_wb, wb_falling, wb_armed}, 0);
      send(8'h02); send(8'h00); send(8'h03);
      stall_len(n);
      check("R6 stall cycles", n, 3 * UNIT);
      send(8'h02); send(8'h00); send(8'h00);
      stall_len(n);
      check("R6 zero delay", n, 0);
      send(8'h03); send(8'h03);
      @(negedge clk);
      check("R7 nop no flags", {27'b0, done, error, multi_wb, wb_falling, wb_armed}, 0);
      send(8'h06);
      @(negedge clk);
      check("R9 done", 32'(done), 1);
      check("R9 armed", 32'(wb_armed), 1);
      check("R9 in_ready", 32'(in_ready), 0);

      do_reset();
      send(8'h07);
      @(negedge clk);
      check("R10 error", 32'(error), 1);
      check("R10 done clear", 32'(done), 0);
      check("R10 in_ready", 32'(in_ready), 0);

      do_reset();
      send(8'h01); send(8'h00); send(8'h02);
      @(negedge clk);
      check("R5 error", 32'(error), 1);
      check("R5 in_ready", 32'(in_ready), 0);
      check("R5 no write", nlog, 0);

      do_reset();
      @(negedge clk);
      check("R11 error cleared", 32'(error), 0);
      check("R1 ready after reset", 32'(in_ready), 1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule